// File: doc/BRIEF.md
# Cache Line Fill Buffer with Critical-Word Forwarding

This block gathers one cache line from a bus that delivers a doubleword per beat. A fill is opened with the line address, the index of the doubleword the requester is waiting for, and a flag that says whether the line may go into the cache. The bus returns the waiting doubleword first and then the rest of the line in wrapping order. The first beat is passed straight to the requester in the same cycle it appears on the bus. Each beat is also stored in the buffer, and a per-beat valid mask records what has come in.

While the line is still filling, a read port answers requests to the same line. A request to a doubleword already in the buffer is answered on the next cycle. A request to a doubleword still in flight waits until that beat lands. Once every beat is in, the block pulses a completion flag. For cacheable fills it also presents the whole line, with its address, to the cache for one cycle. Non-cacheable lines are never written to the cache. The buffer keeps the line and goes on serving hits until the next fill opens. With a 32-bit instruction word, a full buffer therefore holds eight non-cacheable instructions.

Top module: `lfb_line_fill`

## Requirements
- R1: After reset no fill is open: start_ready and rd_ready are 1, and fwd_valid, fill_done, wr_valid, rd_ack and rd_miss are 0.
- R2: Beat k of a fill (k counting from 0) holds doubleword index (start_idx + k) mod 4. Doubleword i sits at bits [64*i+63 : 64*i] of wr_line_data.
- R3: fwd_valid is 1 only in the cycle in which the first beat of a fill is on the bus, with fwd_data equal to bus_data.
- R4: The cycle after the fourth beat is taken, fill_done is 1 for exactly one cycle. For a cacheable fill, wr_valid is 1 in that same cycle, with wr_line set to the fill's line address and wr_line_data holding the complete line.
- R5: A non-cacheable fill never raises wr_valid.
- R6: During a fill, a read of the fill's line to a doubleword that has already arrived gets rd_ack with that doubleword on the next cycle.
- R7: A read to a doubleword not yet received drops rd_ready and gets rd_ack, with the arriving data, in the cycle after that beat is taken. This includes a beat taken in the same cycle as the read.
- R8: After completion, cacheable and non-cacheable lines alike keep answering hits until the next fill starts.
- R9: A read accepted while the buffer is empty, or to a different line, gives rd_miss on the next cycle and no rd_ack.
- R10: A start request while a fill is open and a bus beat while no fill is open are ignored: buffer contents and fill progress are unchanged.
- R11: start_ready is 0 exactly while a fill is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Open a fill |
| start_line | input | LINE_AW | Line address of the fill |
| start_idx | input | IDX_W | Index of the critical doubleword |
| start_cacheable | input | 1 | Line may be written to the cache |
| start_ready | output | 1 | No fill open; start is accepted |
| bus_valid | input | 1 | A beat is on the bus |
| bus_data | input | BEAT_W | Beat data |
| fwd_valid | output | 1 | Critical doubleword bypass valid |
| fwd_data | output | BEAT_W | Critical doubleword |
| rd_en | input | 1 | Read request |
| rd_line | input | LINE_AW | Line address of the read |
| rd_idx | input | IDX_W | Doubleword index of the read |
| rd_ready | output | 1 | Read port free (no read waiting) |
| rd_ack | output | 1 | Read answered from the buffer |
| rd_miss | output | 1 | Read not held by the buffer |
| rd_data | output | BEAT_W | Read data |
| fill_done | output | 1 | Fill completed (one cycle) |
| wr_valid | output | 1 | Cache line write strobe |
| wr_line | output | LINE_AW | Line address to write |
| wr_line_data | output | LINE_W | Full line to write |

## Verification
The hardest case to reach is a read that lands on a doubleword in flight. This covers a read issued in the very cycle its beat is on the bus, and a read still waiting when the last beat completes the line. To reach these, the stimulus issues reads ahead of the wrapping beat order and holds bus_valid low for chosen cycles. It also starts fills at every critical index so the wrap passes through each position. Stray starts and stray beats are inserted and then read back through the read port. This shows that they left the buffer unchanged.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
   typedef enum logic [1:0] {
      PH_EMPTY = 2'd0,
      PH_FILL  = 2'd1,
      PH_HOLD  = 2'd2
   } lfb_phase_e;

   function automatic int lfb_beat_count(input int line_bytes, input int beat_w);
      return (line_bytes * 8) / beat_w;
   endfunction
endpackage

// File: rtl/lfb_seq.sv
module lfb_seq
   import lfb_pkg::*;
#(
   parameter int BEATS   = 4,
   parameter int IDX_W   = 2,
   parameter int LINE_AW = 27
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_valid,
   input  logic [LINE_AW-1:0]   start_line,
   input  logic [IDX_W-1:0]     start_idx,
   input  logic                 start_cacheable,
   input  logic                 bus_valid,
   output lfb_phase_e           phase,
   output logic [LINE_AW-1:0]   line_q,
   output logic [BEATS-1:0]     mask,
   output logic                 beat_take,
   output logic [IDX_W-1:0]     beat_idx,
   output logic                 first_beat,
   output logic                 fill_done,
   output logic                 wr_valid
);
   localparam int CNT_W = IDX_W + 1;

   lfb_phase_e         phase_q;
   logic [IDX_W-1:0]   nxt_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [BEATS-1:0]   mask_q;
   logic               cache_q;
   logic               done_q;
   logic               wrv_q;
   logic               last_beat;
   logic               open_fill;

   assign beat_take  = (phase_q == PH_FILL) && bus_valid;
   assign beat_idx   = nxt_q;
   assign first_beat = beat_take && (cnt_q == '0);
   assign last_beat  = beat_take && (cnt_q == CNT_W'(BEATS - 1));
   assign open_fill  = start_valid && (phase_q != PH_FILL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_EMPTY;
         line_q  <= '0;
         nxt_q   <= '0;
         cnt_q   <= '0;
         mask_q  <= '0;
         cache_q <= 1'b0;
         done_q  <= 1'b0;
         wrv_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         wrv_q  <= 1'b0;
         if (open_fill) begin
            phase_q <= PH_FILL;
            line_q  <= start_line;
            nxt_q   <= start_idx;
            cnt_q   <= '0;
            mask_q  <= '0;
            cache_q <= start_cacheable;
         end else if (beat_take) begin
            mask_q[nxt_q] <= 1'b1;
            nxt_q         <= nxt_q + 1'b1;
            cnt_q         <= cnt_q + 1'b1;
            if (last_beat) begin
               phase_q <= PH_HOLD;
               done_q  <= 1'b1;
               wrv_q   <= cache_q;
            end
         end
      end
   end

   assign phase     = phase_q;
   assign mask      = mask_q;
   assign fill_done = done_q;
   assign wr_valid  = wrv_q;
endmodule

// File: rtl/lfb_store.sv
module lfb_store #(
   parameter int BEATS  = 4,
   parameter int BEAT_W = 64,
   parameter int IDX_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [BEAT_W-1:0]       wr_data,
   output logic [BEATS*BEAT_W-1:0] line_flat
);
   for (genvar g = 0; g < BEATS; g++) begin : g_slot
      logic [BEAT_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) slot_q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g))) slot_q <= wr_data;
      end
      assign line_flat[g*BEAT_W +: BEAT_W] = slot_q;
   end
endmodule

// File: rtl/lfb_read.sv
module lfb_read
   import lfb_pkg::*;
#(
   parameter int BEATS   = 4,
   parameter int BEAT_W  = 64,
   parameter int IDX_W   = 2,
   parameter int LINE_AW = 27
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_en,
   input  logic [LINE_AW-1:0]      rd_line,
   input  logic [IDX_W-1:0]        rd_idx,
   input  lfb_phase_e              phase,
   input  logic [LINE_AW-1:0]      line_q,
   input  logic [BEATS-1:0]        mask,
   input  logic                    beat_take,
   input  logic [IDX_W-1:0]        beat_idx,
   input  logic [BEAT_W-1:0]       bus_data,
   input  logic [BEATS*BEAT_W-1:0] line_flat,
   output logic                    rd_ready,
   output logic                    rd_ack,
   output logic                    rd_miss,
   output logic [BEAT_W-1:0]       rd_data
);
   logic               pend_q;
   logic [IDX_W-1:0]   pidx_q;
   logic               ack_q;
   logic               miss_q;
   logic [BEAT_W-1:0]  data_q;

   logic [IDX_W-1:0]   cur_idx;
   logic               accept;
   logic               hit;
   logic               incoming;
   logic               avail;
   logic [BEAT_W-1:0]  sel_data;

   always_comb begin
      cur_idx  = pend_q ? pidx_q : rd_idx;
      accept   = rd_en && !pend_q;
      hit      = (phase != PH_EMPTY) && (rd_line == line_q);
      incoming = beat_take && (beat_idx == cur_idx);
      avail    = mask[cur_idx] || incoming;
      sel_data = incoming ? bus_data : line_flat[cur_idx*BEAT_W +: BEAT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         pidx_q <= '0;
         ack_q  <= 1'b0;
         miss_q <= 1'b0;
         data_q <= '0;
      end else begin
         ack_q  <= 1'b0;
         miss_q <= 1'b0;
         if (accept) begin
            if (!hit) begin
               miss_q <= 1'b1;
            end else if (avail) begin
               ack_q  <= 1'b1;
               data_q <= sel_data;
            end else begin
               pend_q <= 1'b1;
               pidx_q <= rd_idx;
            end
         end else if (pend_q && avail) begin
            ack_q  <= 1'b1;
            data_q <= sel_data;
            pend_q <= 1'b0;
         end
      end
   end

   assign rd_ready = !pend_q;
   assign rd_ack   = ack_q;
   assign rd_miss  = miss_q;
   assign rd_data  = data_q;
endmodule

// File: rtl/lfb_line_fill.sv
module lfb_line_fill
   import lfb_pkg::*;
#(
   parameter int BEAT_W     = 64,
   parameter int LINE_BYTES = 32,
   parameter int LINE_AW    = 27,
   parameter int BEATS      = lfb_beat_count(LINE_BYTES, BEAT_W),
   parameter int IDX_W      = $clog2(BEATS),
   parameter int LINE_W     = LINE_BYTES * 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_valid,
   input  logic [LINE_AW-1:0]  start_line,
   input  logic [IDX_W-1:0]    start_idx,
   input  logic                start_cacheable,
   output logic                start_ready,
   input  logic                bus_valid,
   input  logic [BEAT_W-1:0]   bus_data,
   output logic                fwd_valid,
   output logic [BEAT_W-1:0]   fwd_data,
   input  logic                rd_en,
   input  logic [LINE_AW-1:0]  rd_line,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic                rd_ready,
   output logic                rd_ack,
   output logic                rd_miss,
   output logic [BEAT_W-1:0]   rd_data,
   output logic                fill_done,
   output logic                wr_valid,
   output logic [LINE_AW-1:0]  wr_line,
   output logic [LINE_W-1:0]   wr_line_data
);
   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("lfb_line_fill: beat count must be a power of two of at least 2");
   end
   if ((LINE_BYTES * 8) % BEAT_W != 0 || LINE_W != BEATS * BEAT_W) begin : g_bad_width
      $error("lfb_line_fill: line width must be a whole number of beats");
   end

   lfb_phase_e         phase;
   logic [LINE_AW-1:0] line_q;
   logic [BEATS-1:0]   mask;
   logic               beat_take;
   logic [IDX_W-1:0]   beat_idx;
   logic               first_beat;
   logic [LINE_W-1:0]  line_flat;

   lfb_seq #(.BEATS(BEATS), .IDX_W(IDX_W), .LINE_AW(LINE_AW)) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_valid     (start_valid),
      .start_line      (start_line),
      .start_idx       (start_idx),
      .start_cacheable (start_cacheable),
      .bus_valid       (bus_valid),
      .phase           (phase),
      .line_q          (line_q),
      .mask            (mask),
      .beat_take       (beat_take),
      .beat_idx        (beat_idx),
      .first_beat      (first_beat),
      .fill_done       (fill_done),
      .wr_valid        (wr_valid)
   );

   lfb_store #(.BEATS(BEATS), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (beat_take),
      .wr_idx    (beat_idx),
      .wr_data   (bus_data),
      .line_flat (line_flat)
   );

   lfb_read #(.BEATS(BEATS), .BEAT_W(BEAT_W), .IDX_W(IDX_W), .LINE_AW(LINE_AW)) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_line   (rd_line),
      .rd_idx    (rd_idx),
      .phase     (phase),
      .line_q    (line_q),
      .mask      (mask),
      .beat_take (beat_take),
      .beat_idx  (beat_idx),
      .bus_data  (bus_data),
      .line_flat (line_flat),
      .rd_ready  (rd_ready),
      .rd_ack    (rd_ack),
      .rd_miss   (rd_miss),
      .rd_data   (rd_data)
   );

   assign start_ready  = (phase != PH_FILL);
   assign fwd_valid    = first_beat;
   assign fwd_data     = bus_data;
   assign wr_line      = line_q;
   assign wr_line_data = line_flat;
endmodule

// File: rtl/lfb_line_fill_chk.sv
module lfb_line_fill_chk (
   input logic clk,
   input logic rst_n,
   input logic start_valid,
   input logic start_ready,
   input logic start_cacheable,
   input logic fwd_valid,
   input logic rd_en,
   input logic rd_ready,
   input logic rd_ack,
   input logic rd_miss,
   input logic fill_done,
   input logic wr_valid
);
   logic fill_cache_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fill_cache_q <= 1'b0;
      else if (start_valid && start_ready) fill_cache_q <= start_cacheable;
   end

   assert_fwd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |=> !fwd_valid);

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> !fill_done);

   assert_write_cacheable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (fill_done && fill_cache_q));

   assert_miss_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_miss |-> $past(rd_en && rd_ready));

   assert_ack_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack |-> ($past(rd_en && rd_ready) || $past(!rd_ready)));

   assert_ack_miss_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_ack && rd_miss));

   assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_ready) |-> $past(start_valid));
endmodule

bind lfb_line_fill lfb_line_fill_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_valid     (start_valid),
   .start_ready     (start_ready),
   .start_cacheable (start_cacheable),
   .fwd_valid       (fwd_valid),
   .rd_en           (rd_en),
   .rd_ready        (rd_ready),
   .rd_ack          (rd_ack),
   .rd_miss         (rd_miss),
   .fill_done       (fill_done),
   .wr_valid        (wr_valid)
);

// File: tb/tb_lfb_line_fill.sv
module tb_lfb_line_fill;
   localparam int AW = 27;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_valid = 1'b0;
   logic [AW-1:0]   start_line = '0;
   logic [1:0]      start_idx = '0;
   logic            start_cacheable = 1'b0;
   logic            start_ready;
   logic            bus_valid = 1'b0;
   logic [63:0]     bus_data = '0;
   logic            fwd_valid;
   logic [63:0]     fwd_data;
   logic            rd_en = 1'b0;
   logic [AW-1:0]   rd_line = '0;
   logic [1:0]      rd_idx = '0;
   logic            rd_ready, rd_ack, rd_miss;
   logic [63:0]     rd_data;
   logic            fill_done, wr_valid;
   logic [AW-1:0]   wr_line;
   logic [255:0]    wr_line_data;

   always #2 clk = ~clk;

   lfb_line_fill dut (.*);

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string rd_tag = "R6";

   // behavioural reference state
   int          m_phase, m_nxt, m_cnt, m_pidx;
   bit          m_cache, m_pend, m_ack, m_miss, m_done, m_wr;
   bit [3:0]    m_mask;
   logic [AW-1:0] m_line, m_wrline;
   logic [63:0] m_buf [4];
   logic [63:0] m_rdata;

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_nxt = 0; m_cnt = 0; m_pidx = 0;
         m_cache = 0; m_pend = 0; m_ack = 0; m_miss = 0; m_done = 0; m_wr = 0;
         m_mask = '0; m_line = '0; m_wrline = '0; m_rdata = '0;
         for (int i = 0; i < 4; i++) m_buf[i] = '0;
      end else begin
         automatic bit take = (m_phase == 1) && bus_valid;
         automatic int widx = m_nxt;
         automatic int cidx = m_pend ? m_pidx : int'(rd_idx);
         automatic bit inc = take && (widx == cidx);
         automatic bit av = m_mask[cidx] || inc;
         automatic logic [63:0] sd = inc ? bus_data : m_buf[cidx];
         automatic bit hit = (m_phase != 0) && (rd_line == m_line);
         m_ack = 0; m_miss = 0; m_done = 0; m_wr = 0;
         if (rd_en && !m_pend) begin
            if (!hit) m_miss = 1;
            else if (av) begin m_ack = 1; m_rdata = sd; end
            else begin m_pend = 1; m_pidx = int'(rd_idx); end
         end else if (m_pend && av) begin
            m_ack = 1; m_rdata = sd; m_pend = 0;
         end
         if (start_valid && m_phase != 1) begin
            m_phase = 1; m_line = start_line; m_nxt = int'(start_idx);
            m_cnt = 0; m_mask = '0; m_cache = start_cacheable;
         end else if (take) begin
            m_buf[widx] = bus_data;
            m_mask[widx] = 1'b1;
            m_nxt = (widx + 1) % 4;
            m_cnt++;
            if (m_cnt == 4) begin
               m_phase = 2; m_done = 1; m_wr = m_cache; m_wrline = m_line;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         automatic bit efwd = (m_phase == 1) && bus_valid && (m_cnt == 0);
         chk(fwd_valid == efwd, "R3", 256'(fwd_valid), 256'(efwd));
         if (efwd) chk(fwd_data == bus_data, "R3", 256'(fwd_data), 256'(bus_data));
         chk(start_ready == (m_phase != 1), "R11", 256'(start_ready), 256'(m_phase != 1));
         chk(rd_ready == !m_pend, "R7", 256'(rd_ready), 256'(!m_pend));
         chk(fill_done == m_done, "R4", 256'(fill_done), 256'(m_done));
         chk(wr_valid == m_wr, m_cache ? "R4" : "R5", 256'(wr_valid), 256'(m_wr));
         if (m_wr) begin
            chk(wr_line == m_wrline, "R4", 256'(wr_line), 256'(m_wrline));
            chk(wr_line_data == {m_buf[3], m_buf[2], m_buf[1], m_buf[0]}, "R2",
                wr_line_data, {m_buf[3], m_buf[2], m_buf[1], m_buf[0]});
         end
         chk(rd_miss == m_miss, "R9", 256'(rd_miss), 256'(m_miss));
         chk(rd_ack == m_ack, rd_tag, 256'(rd_ack), 256'(m_ack));
         if (m_ack) chk(rd_data == m_rdata, rd_tag, 256'(rd_data), 256'(m_rdata));
      end
   end

   task automatic step();
      @(posedge clk); #1;
      start_valid = 0; bus_valid = 0; rd_en = 0;
   endtask

   task automatic start(input logic [AW-1:0] ln, input int idx, input bit c);
      start_valid = 1; start_line = ln; start_idx = 2'(idx); start_cacheable = c;
   endtask

   task automatic beat(input logic [AW-1:0] ln, input int k);
      bus_valid = 1; bus_data = {8'hB0 + 8'(k), 24'(ln), 32'hC0DE_0000 + 32'(k)};
   endtask

   task automatic rd(input logic [AW-1:0] ln, input int idx);
      rd_en = 1; rd_line = ln; rd_idx = 2'(idx);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(start_ready === 1'b1 && rd_ready === 1'b1, "R1", 256'({start_ready, rd_ready}), 256'(2'b11));
      chk({fwd_valid, fill_done, wr_valid, rd_ack, rd_miss} === 5'b0, "R1",
          256'({fwd_valid, fill_done, wr_valid, rd_ack, rd_miss}), 256'(0));
      rst_n = 1;
      step();
      // R9: read with an empty buffer; R10: beat with no fill open
      rd_tag = "R9"; rd(27'h10, 1); beat(27'h99, 7); step(); step();

      // cacheable fill, critical index 2, R2 R3 R6 R7 R4
      rd_tag = "R6";
      start(27'h123, 2, 1); step();
      beat(27'h123, 0); step();
      rd(27'h123, 2); beat(27'h123, 1); step();         // R6 hit on received beat
      rd_tag = "R7";
      rd(27'h123, 1); step();                            // R7 waits for last beat
      step();
      beat(27'h123, 2); step();
      beat(27'h123, 3); step();
      step(); step();

      // non-cacheable fill, critical 0, gaps, R5 R10 R8 R9
      rd_tag = "R8";
      start(27'h0AB, 0, 0); step();
      beat(27'h0AB, 10); step();
      start(27'h555, 3, 1); step();                      // R10 start ignored while open
      step();
      rd_tag = "R7";
      rd(27'h0AB, 3); beat(27'h0AB, 11); step();
      beat(27'h0AB, 12); step();
      step();
      beat(27'h0AB, 13); step();
      step();
      rd_tag = "R10";
      beat(27'h777, 99); step();                         // R10 stray beat in hold
      for (int i = 0; i < 4; i++) begin rd(27'h0AB, i); step(); end
      rd_tag = "R9";
      rd(27'h555, 0); step(); step();

      // cacheable fill, critical 3, read in the cycle its beat arrives
      rd_tag = "R7";
      start(27'h3FF, 3, 1); rd(27'h0AB, 2); step();      // R8 hit on held line
      beat(27'h3FF, 20); step();
      rd(27'h3FF, 0); beat(27'h3FF, 21); step();
      rd(27'h3FF, 2); step();
      beat(27'h3FF, 22); step();
      beat(27'h3FF, 23); step();
      rd_tag = "R8";
      for (int i = 0; i < 4; i++) begin rd(27'h3FF, 3 - i); step(); end
      rd_tag = "R9";
      rd(27'h0AB, 0); step();

      // back-to-back fills over every critical index
      rd_tag = "R6";
      for (int c = 0; c < 4; c++) begin
         start(27'h200 + 27'(c), c, c[0]); step();
         for (int k = 0; k < 4; k++) begin
            beat(27'h200 + 27'(c), 40 + 4 * c + k);
            if (k == 2) rd(27'h200 + 27'(c), c);
            step();
         end
         step();
      end
      repeat (3) step();

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule